// File: doc/BRIEF.md
# Shared Register File with Test-and-Set Semaphore

This block holds the handful of hardware registers that sit at the bottom of a shared address space. Two processors reach this space: a host and a local controller. The block decodes the top two bits of the shared address into one of three regions: the registers, the first RAM bank or the second RAM bank. Within the register region it answers four read registers and four write registers, picked by the two lowest address bits and the direction of the access. Data on the shared bus is carried active-low, in both directions. When the block is not driving the bus, the bus is pulled up and reads as all ones.

The write side holds three things: an interrupt-enable bit, a modem control latch and a trigger for a programmed card reset. The read side returns two status nibbles, the modem status lines and a semaphore. A read of the semaphore returns its current value. At the end of that read, the semaphore is set. Two agents can therefore claim a resource with a single indivisible access, and either agent frees it by writing to the same register.

A programmed reset produces a pulse of fixed length and a one-cycle non-maskable interrupt to the local processor. While the pulse lasts, it holds the serial and timer peripherals in reset, drops the interrupt enable, frees the semaphore and blanks the modem control outputs. The modem outputs stay blank until software writes the control latch again. The power-up reset only resets the local processor and never raises the non-maskable interrupt.

Top module: `shared_regfile`

## Requirements
- R1: While `acc_en` is high, the two top address bits pick exactly one region select. Value 00 with every bit from 12 down to 2 at zero raises `sel_regs`, 01 raises `sel_ram1`, 10 raises `sel_ram2`, and 11 raises none. Value 00 with any of bits 12..2 set also raises none.
- R2: Write data is the bitwise inverse of `sh_data_n_in`. A register read drives the inverse of the register value on `sh_data_n_out` with `sh_drive` high. With no register read, `sh_drive` is low and `sh_data_n_out` is 8'hFF.
- R3: Read register 0 returns {`stat0_in`, 4'b0100}. Read register 1 returns {`stat1_in`, 4'b0000}.
- R4: A write to register 1 copies data bit 7 into `irq_en_out` from the next cycle on. Data bits 6..0 have no effect.
- R5: A write to register 2 loads all eight data bits into the modem control latch, which `modem_ctl_out` shows from the next cycle on. Read register 2 returns `modem_stat_in`.
- R6: Read register 3 returns the semaphore in bit 7, with bits 6..0 at zero. The semaphore becomes 1 in the cycle after the last cycle of that read. A read held for several cycles returns the value the semaphore had before the read began.
- R7: Any write to register 3 clears the semaphore from the next cycle on, whatever the data.
- R8: A write to register 0 with data bit 7 at 1 starts a programmed reset when none is running. `prog_rst_out` is then high for exactly RST_CYCLES cycles, starting the next cycle, and `nmi_out` is high only in the first of those cycles. Data bit 7 at 0 has no effect.
- R9: During a programmed reset, and from the cycle it is triggered, the block does four things. It forces the interrupt enable and the semaphore to 0. It forces `modem_ctl_out` to 0 until register 2 is written again after the reset. It holds `periph_rst_out` high.
- R10: `rst` drives `cpu_rst_out` and `periph_rst_out` high and clears all state. It never produces `nmi_out` or `prog_rst_out`.
- R11: An access whose address lies in region 00 but has any of bits 12..2 set changes no register and does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| acc_en | input | 1 | Shared bus access in progress |
| acc_rd | input | 1 | Access direction: 1 is a read, 0 is a write |
| sh_addr | input | ADDR_W | Shared address |
| sh_data_n_in | input | 8 | Active-low write data |
| sh_data_n_out | output | 8 | Active-low read data; 8'hFF when idle |
| sh_drive | output | 1 | Block is driving the read data |
| sel_regs | output | 1 | Register region selected |
| sel_ram1 | output | 1 | First RAM bank selected |
| sel_ram2 | output | 1 | Second RAM bank selected |
| stat0_in | input | 4 | Status nibble for read register 0 |
| stat1_in | input | 4 | Status nibble for read register 1 |
| modem_stat_in | input | 8 | Modem status lines |
| modem_ctl_out | output | 8 | Modem control outputs, 0 while blanked |
| irq_en_out | output | 1 | Host interrupt enable |
| prog_rst_out | output | 1 | Programmed reset pulse |
| nmi_out | output | 1 | Non-maskable interrupt to the local processor |
| periph_rst_out | output | 1 | Reset to the serial and timer peripherals |
| cpu_rst_out | output | 1 | Reset to the local processor |

## Verification
The semaphore is tried in three ways: single-cycle reads separated by idle cycles, a read held over two cycles, and a write that clears it. Together these separate a flag that sets at the end of a read from one that sets at its start or on every cycle of it. The write registers are loaded with patterns whose bit 7 and low bits disagree, which shows whether only the documented bits are stored. The address patterns place the access in each region, including the unused region, and also just above the register window, which exposes incomplete decoding. A programmed reset is fired with the interrupt enable set, the semaphore held and the modem latch loaded. Observing the outputs across the whole pulse and after it confirms the pulse length, the single-cycle interrupt and that the modem outputs stay blank until rewritten.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_IRQ   = 2'd1,
        REG_MODEM = 2'd2,
        REG_SEM   = 2'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        RGN_REGS = 2'd0,
        RGN_RAM1 = 2'd1,
        RGN_RAM2 = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic     hit;
        logic     rd;
        logic     wr;
        reg_idx_e idx;
    } reg_access_t;

    function automatic region_e region_of(input logic [1:0] top_bits);
        return region_e'(top_bits);
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic [3:0] nib,
                                                      input logic       mark);
        return {nib, 1'b0, mark, 2'b00};
    endfunction

endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
    import shreg_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              acc_en,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] addr,
    output reg_access_t       acc,
    output logic              sel_regs,
    output logic              sel_ram1,
    output logic              sel_ram2
);
    localparam int HI = ADDR_W - 1;
    localparam int LO = ADDR_W - 2;

    region_e rgn;
    logic    win_zero;

    always_comb begin
        rgn      = region_of(addr[HI:LO]);
        win_zero = (addr[HI:2] == '0);
        acc.hit  = acc_en && win_zero;
        acc.rd   = acc.hit && acc_rd;
        acc.wr   = acc.hit && !acc_rd;
        acc.idx  = reg_idx_e'(addr[1:0]);
        sel_regs = acc.hit;
        sel_ram1 = acc_en && (rgn == RGN_RAM1);
        sel_ram2 = acc_en && (rgn == RGN_RAM2);
    end
endmodule

// File: rtl/shreg_reset_seq.sv
module shreg_reset_seq #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic busy,
    output logic nmi
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            nmi  <= 1'b0;
        end else begin
            nmi <= trig;
            if (trig) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == LAST) busy <= 1'b0;
                else             cnt  <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/shreg_sem.sv
module shreg_sem (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic rd_now,
    output logic rd_q,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            flag <= 1'b0;
        end else begin
            rd_q <= rd_now;
            if (clr)                  flag <= 1'b0;
            else if (rd_q && !rd_now) flag <= 1'b1;
        end
    end
endmodule

// File: rtl/shreg_wregs.sv
module shreg_wregs
    import shreg_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  reg_access_t       acc,
    input  logic [DATA_W-1:0] wdata,
    output logic              irq_en,
    output logic [DATA_W-1:0] ctl,
    output logic              ctl_valid
);
    always_ff @(posedge clk) begin
        if (clr) begin
            irq_en    <= 1'b0;
            ctl       <= '0;
            ctl_valid <= 1'b0;
        end else if (acc.wr) begin
            case (acc.idx)
                REG_IRQ: irq_en <= wdata[DATA_W-1];
                REG_MODEM: begin
                    ctl       <= wdata;
                    ctl_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/shared_regfile.sv
module shared_regfile
    import shreg_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] sh_addr,
    input  logic [7:0]        sh_data_n_in,
    output logic [7:0]        sh_data_n_out,
    output logic              sh_drive,
    output logic              sel_regs,
    output logic              sel_ram1,
    output logic              sel_ram2,
    input  logic [3:0]        stat0_in,
    input  logic [3:0]        stat1_in,
    input  logic [7:0]        modem_stat_in,
    output logic [7:0]        modem_ctl_out,
    output logic              irq_en_out,
    output logic              prog_rst_out,
    output logic              nmi_out,
    output logic              periph_rst_out,
    output logic              cpu_rst_out
);
    reg_access_t       acc;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              busy;
    logic              trig;
    logic              clr;
    logic              sem_clr;
    logic              rd_sem;
    logic              rd_sem_q;
    logic              sem_flag;
    logic              irq_en;
    logic [DATA_W-1:0] ctl;
    logic              ctl_valid;

    shreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .acc_en   (acc_en),
        .acc_rd   (acc_rd),
        .addr     (sh_addr),
        .acc      (acc),
        .sel_regs (sel_regs),
        .sel_ram1 (sel_ram1),
        .sel_ram2 (sel_ram2)
    );

    assign wdata   = ~sh_data_n_in;
    assign trig    = acc.wr && (acc.idx == REG_CTRL) && wdata[DATA_W-1] && !busy;
    assign clr     = rst || busy || trig;
    assign rd_sem  = acc.rd && (acc.idx == REG_SEM);
    assign sem_clr = busy || trig || (acc.wr && (acc.idx == REG_SEM));

    shreg_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .busy (busy),
        .nmi  (nmi_out)
    );

    shreg_sem u_sem (
        .clk    (clk),
        .rst    (rst),
        .clr    (sem_clr),
        .rd_now (rd_sem),
        .rd_q   (rd_sem_q),
        .flag   (sem_flag)
    );

    shreg_wregs u_wr (
        .clk       (clk),
        .clr       (clr),
        .acc       (acc),
        .wdata     (wdata),
        .irq_en    (irq_en),
        .ctl       (ctl),
        .ctl_valid (ctl_valid)
    );

    always_comb begin
        case (acc.idx)
            REG_CTRL:  rdata = status_word(stat0_in, 1'b1);
            REG_IRQ:   rdata = status_word(stat1_in, 1'b0);
            REG_MODEM: rdata = modem_stat_in;
            default:   rdata = {sem_flag, {(DATA_W-1){1'b0}}};
        endcase
    end

    assign sh_drive       = acc.rd;
    assign sh_data_n_out  = acc.rd ? ~rdata : '1;
    assign modem_ctl_out  = ctl_valid ? ctl : '0;
    assign irq_en_out     = irq_en;
    assign prog_rst_out   = busy;
    assign periph_rst_out = rst || busy;
    assign cpu_rst_out    = rst;
endmodule

// File: rtl/shreg_checker.sv
module shreg_checker (
    input logic       clk,
    input logic       rst,
    input logic       sel_regs,
    input logic       sel_ram1,
    input logic       sel_ram2,
    input logic       sh_drive,
    input logic [7:0] sh_data_n_out,
    input logic       sem_flag,
    input logic       rd_sem_q,
    input logic       sem_wr,
    input logic       prog_rst_out,
    input logic       nmi_out,
    input logic       irq_en_out,
    input logic [7:0] modem_ctl_out
);
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_regs, sel_ram1, sel_ram2}));

    assert_idle_bus_R2: assert property (@(posedge clk) disable iff (rst)
        !sh_drive |-> (sh_data_n_out == 8'hFF));

    assert_sem_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sem_flag) |-> $past(rd_sem_q));

    assert_sem_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
        sem_wr |=> !sem_flag);

    assert_nmi_starts_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_rst_out) |-> nmi_out);

    assert_nmi_inside_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        nmi_out |-> prog_rst_out);

    assert_quiet_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
        prog_rst_out |-> (!irq_en_out && !sem_flag && modem_ctl_out == 8'h00));

    assert_no_nmi_on_power_R10: assert property (@(posedge clk)
        rst |=> (!nmi_out && !prog_rst_out));
endmodule

bind shared_regfile shreg_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .sel_regs      (sel_regs),
    .sel_ram1      (sel_ram1),
    .sel_ram2      (sel_ram2),
    .sh_drive      (sh_drive),
    .sh_data_n_out (sh_data_n_out),
    .sem_flag      (sem_flag),
    .rd_sem_q      (rd_sem_q),
    .sem_wr        (acc.wr && acc.idx == shreg_pkg::REG_SEM),
    .prog_rst_out  (prog_rst_out),
    .nmi_out       (nmi_out),
    .irq_en_out    (irq_en_out),
    .modem_ctl_out (modem_ctl_out)
);

// File: tb/sim_shared_regfile.sv
`timescale 1ns/1ps
module sim_shared_regfile;
    localparam int RST_CYCLES = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0;
    logic        acc_rd = 1'b0;
    logic [14:0] sh_addr = '0;
    logic [7:0]  sh_data_n_in = 8'hFF;
    logic [7:0]  sh_data_n_out;
    logic        sh_drive, sel_regs, sel_ram1, sel_ram2;
    logic [3:0]  stat0_in = 4'h9;
    logic [3:0]  stat1_in = 4'h6;
    logic [7:0]  modem_stat_in = 8'h3C;
    logic [7:0]  modem_ctl_out;
    logic        irq_en_out, prog_rst_out, nmi_out, periph_rst_out, cpu_rst_out;

    int checks = 0;
    int failures = 0;

    // behavioural model state
    bit       m_irq, m_ctlv, m_sem, m_rd3, m_nmi;
    bit [7:0] m_ctl;
    int       m_rem;

    always #5 clk = ~clk;

    shared_regfile #(.ADDR_W(15), .RST_CYCLES(RST_CYCLES)) u0 (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_rd(acc_rd),
        .sh_addr(sh_addr), .sh_data_n_in(sh_data_n_in),
        .sh_data_n_out(sh_data_n_out), .sh_drive(sh_drive),
        .sel_regs(sel_regs), .sel_ram1(sel_ram1), .sel_ram2(sel_ram2),
        .stat0_in(stat0_in), .stat1_in(stat1_in), .modem_stat_in(modem_stat_in),
        .modem_ctl_out(modem_ctl_out), .irq_en_out(irq_en_out),
        .prog_rst_out(prog_rst_out), .nmi_out(nmi_out),
        .periph_rst_out(periph_rst_out), .cpu_rst_out(cpu_rst_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit r, input bit en, input bit rd,
                       input logic [14:0] a, input logic [7:0] d, input string tag);
        bit       hit, wr, rd3, trig, clr;
        bit [1:0] idx;
        bit [7:0] val;
        @(negedge clk);
        rst = r; acc_en = en; acc_rd = rd; sh_addr = a; sh_data_n_in = ~d;
        #1;
        hit = en && (a[14:2] == 0);
        idx = a[1:0];
        case (idx)
            2'd0: val = {stat0_in, 4'b0100};
            2'd1: val = {stat1_in, 4'b0000};
            2'd2: val = modem_stat_in;
            default: val = {m_sem, 7'b0};
        endcase
        chk({"R1 sel_regs ", tag}, sel_regs, en && a[14:2] == 0);
        chk({"R1 sel_ram1 ", tag}, sel_ram1, en && a[14:13] == 2'b01);
        chk({"R1 sel_ram2 ", tag}, sel_ram2, en && a[14:13] == 2'b10);
        chk({"R2 drive ", tag}, sh_drive, hit && rd);
        chk({"R2 data ", tag}, sh_data_n_out, (hit && rd) ? ~val : 8'hFF);
        chk({"R5 modem_ctl ", tag}, modem_ctl_out, m_ctlv ? m_ctl : 8'h00);
        chk({"R4 irq_en ", tag}, irq_en_out, m_irq);
        chk({"R8 prog_rst ", tag}, prog_rst_out, m_rem > 0);
        chk({"R8 nmi ", tag}, nmi_out, m_nmi);
        chk({"R9 periph_rst ", tag}, periph_rst_out, r || m_rem > 0);
        chk({"R10 cpu_rst ", tag}, cpu_rst_out, r);
        @(posedge clk);
        if (r) begin
            m_irq = 0; m_ctlv = 0; m_ctl = 0; m_sem = 0; m_rd3 = 0; m_nmi = 0; m_rem = 0;
        end else begin
            wr   = hit && !rd;
            rd3  = hit && rd && idx == 2'd3;
            trig = wr && idx == 2'd0 && d[7] && m_rem == 0;
            clr  = trig || m_rem > 0;
            if (clr || (wr && idx == 2'd3)) m_sem = 0;
            else if (m_rd3 && !rd3)         m_sem = 1;
            m_rd3 = rd3;
            if (clr) begin
                m_irq = 0; m_ctlv = 0; m_ctl = 0;
            end else if (wr && idx == 2'd1) m_irq = d[7];
            else if (wr && idx == 2'd2) begin
                m_ctl = d; m_ctlv = 1;
            end
            if (trig) m_rem = RST_CYCLES;
            else if (m_rem > 0) m_rem--;
            m_nmi = trig;
        end
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 15'h0000, 8'h00, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired checks=%0d", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // power-up reset
        cyc(1, 0, 0, 15'h0000, 8'h00, "R10 reset");
        cyc(1, 1, 0, 15'h0000, 8'h80, "R10 write under reset");
        idle("R10 after reset");
        // interrupt enable: only bit 7 counts
        cyc(0, 1, 0, 15'h0001, 8'h80, "R4 set irq");
        idle("R4");
        cyc(0, 1, 0, 15'h0001, 8'h7F, "R4 low bits only");
        idle("R4");
        // status registers
        cyc(0, 1, 1, 15'h0000, 8'h00, "R3 read reg0");
        cyc(0, 1, 1, 15'h0001, 8'h00, "R3 read reg1");
        stat0_in = 4'h3; stat1_in = 4'hC;
        cyc(0, 1, 1, 15'h0000, 8'h00, "R3 reg0 new nibble");
        cyc(0, 1, 1, 15'h0001, 8'h00, "R3 reg1 new nibble");
        // modem latch and status
        cyc(0, 1, 0, 15'h0002, 8'hA5, "R5 write latch");
        cyc(0, 1, 1, 15'h0002, 8'h00, "R5 read status");
        modem_stat_in = 8'hC3;
        cyc(0, 1, 1, 15'h0002, 8'h00, "R5 read status 2");
        // semaphore
        cyc(0, 1, 1, 15'h0003, 8'h00, "R6 first read");
        idle("R6");
        cyc(0, 1, 1, 15'h0003, 8'h00, "R6 second read");
        cyc(0, 1, 0, 15'h0003, 8'h00, "R7 clear");
        cyc(0, 1, 1, 15'h0003, 8'h00, "R6 held read a");
        cyc(0, 1, 1, 15'h0003, 8'h00, "R6 held read b");
        idle("R6");
        cyc(0, 1, 1, 15'h0003, 8'h00, "R6 after held");
        cyc(0, 1, 0, 15'h0003, 8'hFF, "R7 clear ff");
        cyc(0, 1, 1, 15'h0003, 8'h00, "R7 read back");
        // decode boundaries
        cyc(0, 1, 0, 15'h0006, 8'h11, "R11 write above window");
        cyc(0, 1, 1, 15'h0007, 8'h00, "R11 read above window");
        cyc(0, 1, 0, 15'h1001, 8'h00, "R11 high window bit");
        cyc(0, 1, 1, 15'h2003, 8'h00, "R1 ram1");
        cyc(0, 1, 0, 15'h4002, 8'h00, "R1 ram2");
        cyc(0, 1, 1, 15'h6000, 8'h00, "R1 unused");
        idle("R11 state kept");
        // programmed reset with everything live
        cyc(0, 1, 0, 15'h0001, 8'h80, "R9 prep irq");
        cyc(0, 1, 1, 15'h0003, 8'h00, "R9 prep sem");
        cyc(0, 1, 0, 15'h0000, 8'h7F, "R8 bit7 zero");
        idle("R8");
        cyc(0, 1, 0, 15'h0000, 8'h80, "R8 trigger");
        for (int i = 0; i < RST_CYCLES + 2; i++) idle("R9 pulse");
        cyc(0, 1, 1, 15'h0003, 8'h00, "R9 sem cleared");
        idle("R9 blank");
        cyc(0, 1, 0, 15'h0002, 8'h5A, "R9 rewrite latch");
        idle("R9 latch live");
        cyc(0, 1, 0, 15'h0000, 8'h80, "R8 second trigger");
        cyc(0, 1, 0, 15'h0000, 8'h80, "R8 retrigger busy");
        for (int i = 0; i < RST_CYCLES + 1; i++) idle("R8 second pulse");
        cyc(1, 0, 0, 15'h0000, 8'h00, "R10 reset again");
        idle("R10 end");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule